// File: doc/BRIEF.md
# Burst Address Generator with Replay

This block produces the address for each access of one synchronous memory port. On every rising clock edge it takes one of four actions. It can take a new start address from outside, step forward by one, keep its current value, or jump back to the start address it took most recently. Two or more ports of a shared memory each carry their own copy.

Internally a small command selector turns the three request inputs into a single enumerated action. The actions are `CMD_LOAD`, `CMD_REPLAY`, `CMD_STEP` and `CMD_HOLD`. Every edge is a transition into the action picked for that cycle.

- `CMD_LOAD` writes the external address into both the counter and the replay register.
- `CMD_REPLAY` copies the replay register into the counter.
- `CMD_STEP` adds one to the counter and wraps modulo 2^`ADDR_W`.
- `CMD_HOLD` leaves both registers as they are.

A synchronous reset forces both registers to zero, whatever command is present.

The address output comes straight from the counter register. It therefore shows the result of the action one edge after the request is sampled. The width is set by `ADDR_W`, which defaults to 18 and may be set to 17.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the counter and the replay register both become zero. A replay request made right after reset therefore yields address 0.
- R2: When `load_req` is 1 at an edge, `addr_q` equals `load_addr` after that edge.
- R3: When `step_req` is the only request at an edge, `addr_q` becomes its previous value plus one.
- R4: Stepping from the all-ones address gives address 0.
- R5: When no request is high at an edge, `addr_q` keeps its value.
- R6: When `replay_req` is 1 and `load_req` is 0 at an edge, `addr_q` becomes the address taken by the most recent load, or 0 if there has been no load since reset.
- R7: `load_req` wins over `replay_req` and `step_req` when they are high together.
- R8: `replay_req` wins over `step_req` when both are high and `load_req` is 0.
- R9: Only a load changes the replay register. Steps and replays leave it unchanged, so a later replay returns to the last loaded address.
- R10: The width of `load_addr` and `addr_q` is `ADDR_W`, which defaults to 18 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_req | input | 1 | Take `load_addr` as the new start address |
| load_addr | input | ADDR_W | External start address |
| replay_req | input | 1 | Return to the last loaded address |
| step_req | input | 1 | Advance the address by one |
| addr_q | output | ADDR_W | Registered address for the current access |

## Verification
Every cycle, the bound checker compares `addr_q` with what the previous cycle's requests imply. It covers the post-reset value, loads, single steps, the wrap from all-ones, holds, and replays against a shadow copy of the last loaded address. That comparison also covers the priority order.

Some properties only show up over long sequences. The bench's scenarios cover these: the replay register surviving many steps and replays, a reset in the middle of a burst clearing the replay target, and mixed request patterns under random stimulus. The bench also checks the default port width.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    // Resolved action for one clock edge
    typedef enum logic [1:0] {
        CMD_HOLD   = 2'd0,
        CMD_STEP   = 2'd1,
        CMD_REPLAY = 2'd2,
        CMD_LOAD   = 2'd3
    } burst_cmd_e;

endpackage

// File: rtl/burst_cmd_sel.sv
module burst_cmd_sel
    import burst_addr_pkg::*;
(
    input  logic       load_req,
    input  logic       replay_req,
    input  logic       step_req,
    output burst_cmd_e cmd
);

    // Fixed priority: load, replay, step, hold
    always_comb begin
        if (load_req) begin
            cmd = CMD_LOAD;
        end else if (replay_req) begin
            cmd = CMD_REPLAY;
        end else if (step_req) begin
            cmd = CMD_STEP;
        end else begin
            cmd = CMD_HOLD;
        end
    end

endmodule

// File: rtl/burst_replay_reg.sv
module burst_replay_reg
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  burst_cmd_e        cmd,
    input  logic [ADDR_W-1:0] load_addr,
    output logic [ADDR_W-1:0] replay_addr
);

    logic [ADDR_W-1:0] saved_d;

    // Only a load updates the saved start address
    always_comb begin
        unique case (cmd)
            CMD_LOAD:   saved_d = load_addr;
            CMD_REPLAY: saved_d = replay_addr;
            CMD_STEP:   saved_d = replay_addr;
            CMD_HOLD:   saved_d = replay_addr;
            default:    saved_d = replay_addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            replay_addr <= '0;
        end else begin
            replay_addr <= saved_d;
        end
    end

endmodule

// File: rtl/burst_count_reg.sv
module burst_count_reg
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  burst_cmd_e        cmd,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [ADDR_W-1:0] replay_addr,
    output logic [ADDR_W-1:0] count_q
);

    localparam logic [ADDR_W-1:0] STEP_ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] count_d;

    // Next-value selector; the add wraps naturally at ADDR_W bits
    always_comb begin
        unique case (cmd)
            CMD_LOAD:   count_d = load_addr;
            CMD_REPLAY: count_d = replay_addr;
            CMD_STEP:   count_d = count_q + STEP_ONE;
            CMD_HOLD:   count_d = count_q;
            default:    count_d = count_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_req,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              replay_req,
    input  logic              step_req,
    output logic [ADDR_W-1:0] addr_q
);

    burst_cmd_e        cmd;
    logic [ADDR_W-1:0] replay_addr;
    logic [ADDR_W-1:0] count_q;

    burst_cmd_sel u_sel (
        .load_req   (load_req),
        .replay_req (replay_req),
        .step_req   (step_req),
        .cmd        (cmd)
    );

    burst_replay_reg #(.ADDR_W(ADDR_W)) u_replay (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .load_addr   (load_addr),
        .replay_addr (replay_addr)
    );

    burst_count_reg #(.ADDR_W(ADDR_W)) u_count (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .load_addr   (load_addr),
        .replay_addr (replay_addr),
        .count_q     (count_q)
    );

    assign addr_q = count_q;

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              load_req,
    input logic [ADDR_W-1:0] load_addr,
    input logic              replay_req,
    input logic              step_req,
    input logic [ADDR_W-1:0] addr_q
);

    logic              rst_seen;
    logic [ADDR_W-1:0] shadow_q;

    // Independent record of the last loaded start address
    always_ff @(posedge clk) begin
        rst_seen <= rst;
        if (rst) begin
            shadow_q <= '0;
        end else if (load_req) begin
            shadow_q <= load_addr;
        end
    end

    // R1: reset clears the address
    always_ff @(negedge clk) begin
        if (rst_seen === 1'b1) begin
            a_reset_zero_r1: assert (addr_q == '0);
        end
    end

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        load_req |=> addr_q == $past(load_addr));

    p_load_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (load_req && (replay_req || step_req)) |=> addr_q == $past(load_addr));

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!load_req && !replay_req && step_req) |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));

    p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (!load_req && !replay_req && step_req && (&addr_q)) |=> addr_q == '0);

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!load_req && !replay_req && !step_req) |=> $stable(addr_q));

    // R6, R8 and R9: replay returns to the shadow of the last load
    p_replay_r6: assert property (@(posedge clk) disable iff (rst)
        (!load_req && replay_req) |=> addr_q == shadow_q);

    p_replay_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (!load_req && replay_req && step_req) |=> addr_q == shadow_q);

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_req   (load_req),
    .load_addr  (load_addr),
    .replay_req (replay_req),
    .step_req   (step_req),
    .addr_q     (addr_q)
);

// File: tb/burst_addr_gen_bench.sv
`timescale 1ns/1ps
module burst_addr_gen_bench;

    localparam int W = 18;
    localparam logic [W-1:0] ONES = '1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_req = 1'b0;
    logic [W-1:0] load_addr = '0;
    logic         replay_req = 1'b0;
    logic         step_req = 1'b0;
    logic [W-1:0] addr_q;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [W-1:0] exp_addr;
    logic [W-1:0] exp_saved;

    always #2 clk = ~clk;

    burst_addr_gen u_burst_addr_gen (
        .clk        (clk),
        .rst        (rst),
        .load_req   (load_req),
        .load_addr  (load_addr),
        .replay_req (replay_req),
        .step_req   (step_req),
        .addr_q     (addr_q)
    );

    function automatic logic [W-1:0] model_addr(input logic r, input logic l,
            input logic p, input logic s, input logic [W-1:0] la,
            input logic [W-1:0] cur, input logic [W-1:0] sav);
        if (r)      return '0;
        else if (l) return la;
        else if (p) return sav;
        else if (s) return W'(cur + 1'b1);
        else        return cur;
    endfunction

    function automatic logic [W-1:0] model_saved(input logic r, input logic l,
            input logic [W-1:0] la, input logic [W-1:0] sav);
        if (r)      return '0;
        else if (l) return la;
        else        return sav;
    endfunction

    function automatic string pick_req(input logic r, input logic l,
            input logic p, input logic s, input logic [W-1:0] cur);
        if (r)           return "R1";
        else if (l && (p || s)) return "R7";
        else if (l)      return "R2";
        else if (p && s) return "R8";
        else if (p)      return "R6";
        else if (s && cur == ONES) return "R4";
        else if (s)      return "R3";
        else             return "R5";
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: addr_q actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at negedge, let the posedge act, check at the next negedge
    task automatic cycle(input logic r, input logic l, input logic [W-1:0] la,
            input logic p, input logic s, input string tag);
        string req;
        req = (tag != "") ? tag : pick_req(r, l, p, s, exp_addr);
        rst = r; load_req = l; load_addr = la; replay_req = p; step_req = s;
        exp_addr  = model_addr(r, l, p, s, la, exp_addr, exp_saved);
        exp_saved = model_saved(r, l, la, exp_saved);
        @(negedge clk);
        check(req, addr_q, exp_addr);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        exp_addr  = '0;
        exp_saved = '0;
        @(negedge clk);
        cycle(1'b1, 1'b0, '0, 1'b0, 1'b0, "R1");

        // R10: default width
        n_checks++;
        if ($bits(addr_q) != 18) begin
            n_fail++;
            $display("FAIL R10: width actual %0d expected 18", $bits(addr_q));
        end

        // R1: replay straight after reset gives zero
        cycle(1'b0, 1'b0, '0, 1'b1, 1'b0, "R1");
        cycle(1'b0, 1'b1, 18'h01230, 1'b0, 1'b0, "R2");
        cycle(1'b0, 1'b0, '0, 1'b0, 1'b1, "R3");
        cycle(1'b0, 1'b0, '0, 1'b0, 1'b1, "R3");
        cycle(1'b0, 1'b0, 18'h3AAAA, 1'b0, 1'b0, "R5");
        cycle(1'b0, 1'b0, '0, 1'b0, 1'b0, "R5");
        // R9: steps and replays leave the saved address alone
        for (int i = 0; i < 5; i++) cycle(1'b0, 1'b0, '0, 1'b0, 1'b1, "R9");
        cycle(1'b0, 1'b0, '0, 1'b1, 1'b0, "R6");
        cycle(1'b0, 1'b0, '0, 1'b0, 1'b1, "R9");
        cycle(1'b0, 1'b0, '0, 1'b1, 1'b0, "R9");
        // R4: wrap from all-ones
        cycle(1'b0, 1'b1, ONES, 1'b0, 1'b0, "R2");
        cycle(1'b0, 1'b0, '0, 1'b0, 1'b1, "R4");
        cycle(1'b0, 1'b0, '0, 1'b0, 1'b1, "R3");
        // R7 and R8: priority
        cycle(1'b0, 1'b1, 18'h15555, 1'b1, 1'b1, "R7");
        cycle(1'b0, 1'b0, '0, 1'b0, 1'b1, "R3");
        cycle(1'b0, 1'b0, '0, 1'b1, 1'b1, "R8");
        cycle(1'b0, 1'b1, 18'h00042, 1'b0, 1'b1, "R7");
        // R1: reset mid-burst clears the replay target
        cycle(1'b0, 1'b0, '0, 1'b0, 1'b1, "R3");
        cycle(1'b1, 1'b0, '0, 1'b0, 1'b1, "R1");
        cycle(1'b0, 1'b0, '0, 1'b1, 1'b0, "R1");

        // Random mix, loads weighted low so bursts form
        for (int i = 0; i < 3000; i++) begin
            logic l, p, s, r;
            logic [W-1:0] la;
            r  = ($urandom_range(0, 199) == 0);
            l  = ($urandom_range(0, 9) == 0);
            p  = ($urandom_range(0, 7) == 0);
            s  = ($urandom_range(0, 3) != 0);
            la = ($urandom_range(0, 5) == 0) ? W'(ONES - W'($urandom_range(0, 3)))
                                             : W'($urandom);
            cycle(r, l, la, p, s, "");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule